// File: doc/BRIEF.md
# Victim Line Buffer

This block is a small, fully associative side store that sits between a direct-mapped cache and the next memory level. Every line that the direct-mapped cache throws out is handed to the buffer together with its full line address. When the main cache misses, the buffer is consulted in the same cycle. Each entry has its own comparator, so all entries are checked in parallel. A hit hands the stored line back to the main cache, and no request goes further down. A miss raises a request to the next level.

A hit and an eviction presented in the same cycle form a swap. The line that leaves the main cache lands in the entry that the returning line has just freed. A hit with no eviction simply frees the entry. An eviction that does not swap goes to the lowest-numbered free entry. When every entry is occupied, it goes to the entry named by a round-robin pointer. Because entries are not bound to any cache index, each one stores the complete line address as its tag.

Top module: `victim_buf`

## Requirements
- R1: After reset every entry is empty, the round-robin pointer is 0, and a lookup of any address misses.
- R2: While `lk_valid` is high and a stored entry holds `lk_addr`, `lk_hit` is 1 and `lk_way` gives that entry number in the same cycle. On a miss, `lk_way` is 0.
- R3: While `lk_valid` is high and no entry matches, `nxt_req_valid` is 1 with `nxt_req_addr` equal to `lk_addr` in the same cycle. On a hit, `nxt_req_valid` is 0.
- R4: An eviction that is not part of a swap, made while some entry is empty, is written into the lowest-numbered empty entry and leaves the pointer unchanged.
- R5: An eviction that is not part of a swap, made while all entries are full, overwrites the entry at the pointer. The pointer then steps to the next entry, wrapping from the last entry to 0. No other event moves the pointer.
- R6: A hit together with an eviction in the same cycle writes the evicted address and line into the entry that hit. Other entries and the pointer stay as they were.
- R7: A hit with no eviction empties the entry that hit, so a later lookup of that address misses.
- R8: With `lk_valid` low, `lk_hit`, `swap_valid` and `nxt_req_valid` are 0, and no entry is removed.
- R9: On a hit, `swap_valid` is 1 and `swap_data` carries the stored line of the matching entry in the same cycle. Otherwise `swap_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request after a main-cache miss |
| lk_addr | input | ADDR_W | Line address to look up |
| ev_valid | input | 1 | Evicted line presented by the main cache |
| ev_addr | input | ADDR_W | Full line address of the evicted line |
| ev_data | input | LINE_W | Evicted line contents |
| lk_hit | output | 1 | Lookup matched a stored entry |
| lk_way | output | IDX_W | Number of the matching entry |
| swap_valid | output | 1 | Line returned to the main cache this cycle |
| swap_data | output | LINE_W | Returned line contents |
| nxt_req_valid | output | 1 | Request to the next memory level |
| nxt_req_addr | output | ADDR_W | Address of that request |

## Verification
The assertions rely on three properties of the surrounding cache. An evicted address is never already stored in the buffer. It never equals the address being looked up in the same cycle. Stored addresses are therefore unique, so at most one comparator fires at a time. The bench follows the same rules in its directed sequences and in its random phase. In the random phase, each eviction address is drawn again until it is absent from the reference model's contents and differs from the current lookup address.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

   // Update action taken on the entry array at the next clock edge
   typedef enum logic [2:0] {
      VCB_IDLE    = 3'd0,
      VCB_FILL    = 3'd1,  // evicted line into an empty entry
      VCB_REPLACE = 3'd2,  // evicted line over the pointed entry
      VCB_SWAP    = 3'd3,  // evicted line into the entry that hit
      VCB_DROP    = 3'd4   // entry that hit leaves the buffer
   } vcb_act_e;

endpackage

// File: rtl/vcb_entry_store.sv
module vcb_entry_store #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26,
   parameter int LINE_W  = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_idx,
   input  logic [ADDR_W-1:0]              wr_tag,
   input  logic [LINE_W-1:0]              wr_data,
   input  logic                           clr_en,
   input  logic [IDX_W-1:0]               clr_idx,
   output logic [ENTRIES-1:0]             valid_o,
   output logic [ENTRIES-1:0][ADDR_W-1:0] tag_o,
   output logic [ENTRIES-1:0][LINE_W-1:0] data_o
);

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      logic sel_wr, sel_clr;
      assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(i));
      assign sel_clr = clr_en && (clr_idx == IDX_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       valid_o[i] <= 1'b0;
         else if (sel_wr)  valid_o[i] <= 1'b1;
         else if (sel_clr) valid_o[i] <= 1'b0;
      end

      always_ff @(posedge clk) begin
         if (sel_wr) begin
            tag_o[i]  <= wr_tag;
            data_o[i] <= wr_data;
         end
      end
   end

endmodule

// File: rtl/vcb_tag_match.sv
module vcb_tag_match #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26,
   parameter int LINE_W  = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                           lk_valid,
   input  logic [ADDR_W-1:0]              lk_addr,
   input  logic [ENTRIES-1:0]             valid_i,
   input  logic [ENTRIES-1:0][ADDR_W-1:0] tag_i,
   input  logic [ENTRIES-1:0][LINE_W-1:0] data_i,
   output logic [ENTRIES-1:0]             match_o,
   output logic                           hit_o,
   output logic [IDX_W-1:0]               way_o,
   output logic [LINE_W-1:0]              data_o
);

   // one comparator per entry, all in parallel
   for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
      assign match_o[i] = lk_valid && valid_i[i] && (tag_i[i] == lk_addr);
   end

   assign hit_o = |match_o;

   // AND-OR encode, valid because stored addresses are unique
   always_comb begin
      way_o  = '0;
      data_o = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match_o[i]) begin
            way_o  = way_o | IDX_W'(i);
            data_o = data_o | data_i[i];
         end
      end
   end

endmodule

// File: rtl/vcb_repl_sel.sv
module vcb_repl_sel #(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic               advance,
   output logic               any_free_o,
   output logic [IDX_W-1:0]   free_idx_o,
   output logic [IDX_W-1:0]   ptr_o
);

   localparam bit POW2 = (ENTRIES == (1 << IDX_W));

   // lowest-numbered empty entry wins
   always_comb begin
      any_free_o = 1'b0;
      free_idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!valid_i[i]) begin
            any_free_o = 1'b1;
            free_idx_o = IDX_W'(i);
         end
      end
   end

   logic [IDX_W-1:0] ptr_nxt;

   if (POW2) begin : g_wrap_free
      assign ptr_nxt = ptr_o + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_nxt = (ptr_o == IDX_W'(ENTRIES - 1)) ? '0 : ptr_o + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ptr_o <= '0;
      else if (advance) ptr_o <= ptr_nxt;
   end

endmodule

// File: rtl/victim_buf.sv
module victim_buf
   import vcb_pkg::*;
#(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26,
   parameter int LINE_W  = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [ADDR_W-1:0] lk_addr,
   input  logic              ev_valid,
   input  logic [ADDR_W-1:0] ev_addr,
   input  logic [LINE_W-1:0] ev_data,
   output logic              lk_hit,
   output logic [IDX_W-1:0]  lk_way,
   output logic              swap_valid,
   output logic [LINE_W-1:0] swap_data,
   output logic              nxt_req_valid,
   output logic [ADDR_W-1:0] nxt_req_addr
);

   if (ENTRIES < 2) begin : g_bad_entries
      $error("victim_buf: ENTRIES must be at least 2");
   end
   if (ADDR_W < 1 || LINE_W < 1) begin : g_bad_width
      $error("victim_buf: ADDR_W and LINE_W must be positive");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0][ADDR_W-1:0] ent_tag;
   logic [ENTRIES-1:0][LINE_W-1:0] ent_data;
   logic [ENTRIES-1:0]             match_vec;
   logic                           any_hit;
   logic [IDX_W-1:0]               hit_way;
   logic [LINE_W-1:0]              hit_data;
   logic                           any_free;
   logic [IDX_W-1:0]               free_idx;
   logic [IDX_W-1:0]               rr_ptr;
   vcb_act_e                       act;
   logic                           wr_en, clr_en, rr_adv;
   logic [IDX_W-1:0]               wr_idx;

   vcb_tag_match #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_match (
      .lk_valid (lk_valid),
      .lk_addr  (lk_addr),
      .valid_i  (ent_valid),
      .tag_i    (ent_tag),
      .data_i   (ent_data),
      .match_o  (match_vec),
      .hit_o    (any_hit),
      .way_o    (hit_way),
      .data_o   (hit_data)
   );

   vcb_repl_sel #(.ENTRIES(ENTRIES)) u_repl (
      .clk        (clk),
      .rst_n      (rst_n),
      .valid_i    (ent_valid),
      .advance    (rr_adv),
      .any_free_o (any_free),
      .free_idx_o (free_idx),
      .ptr_o      (rr_ptr)
   );

   always_comb begin
      act = VCB_IDLE;
      if (any_hit && ev_valid)  act = VCB_SWAP;
      else if (any_hit)         act = VCB_DROP;
      else if (ev_valid)        act = any_free ? VCB_FILL : VCB_REPLACE;
   end

   always_comb begin
      wr_en  = 1'b0;
      clr_en = 1'b0;
      rr_adv = 1'b0;
      wr_idx = '0;
      unique case (act)
         VCB_FILL:    begin wr_en = 1'b1; wr_idx = free_idx; end
         VCB_REPLACE: begin wr_en = 1'b1; wr_idx = rr_ptr; rr_adv = 1'b1; end
         VCB_SWAP:    begin wr_en = 1'b1; wr_idx = hit_way; end
         VCB_DROP:    clr_en = 1'b1;
         default:     ;
      endcase
   end

   vcb_entry_store #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W), .LINE_W(LINE_W)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_tag  (ev_addr),
      .wr_data (ev_data),
      .clr_en  (clr_en),
      .clr_idx (hit_way),
      .valid_o (ent_valid),
      .tag_o   (ent_tag),
      .data_o  (ent_data)
   );

   assign lk_hit        = any_hit;
   assign lk_way        = hit_way;
   assign swap_valid    = any_hit;
   assign swap_data     = hit_data;
   assign nxt_req_valid = lk_valid && !any_hit;
   assign nxt_req_addr  = lk_addr;

endmodule

// File: rtl/victim_buf_chk.sv
module victim_buf_chk #(
   parameter int ENTRIES = 4,
   parameter int ADDR_W  = 26,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               lk_valid,
   input logic [ADDR_W-1:0]  lk_addr,
   input logic               ev_valid,
   input logic [ADDR_W-1:0]  ev_addr,
   input logic               lk_hit,
   input logic [IDX_W-1:0]   lk_way,
   input logic               swap_valid,
   input logic               nxt_req_valid,
   input logic [ENTRIES-1:0] ent_valid,
   input logic [ENTRIES-1:0] match_vec,
   input logic [IDX_W-1:0]   rr_ptr
);

   // R2
   unique_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   // R3
   req_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(nxt_req_valid && swap_valid));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |-> (!lk_hit && !swap_valid && !nxt_req_valid));

   // R8
   idle_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!lk_valid && !ev_valid) |=> $stable(ent_valid));

   // R7
   drop_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_hit && !ev_valid) |=>
         !(lk_valid && lk_hit && lk_addr == $past(lk_addr)));

   // R6
   swap_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_hit && ev_valid && !(lk_valid && lk_addr == ev_addr)) |=>
         (!(lk_valid && lk_addr == $past(ev_addr)) ||
          (lk_hit && lk_way == $past(lk_way))));

   // R4
   fill_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !(lk_valid && lk_hit) && !(&ent_valid)) |=>
         ($countones(ent_valid) == $countones($past(ent_valid)) + 1));

   // R5
   ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !(lk_valid && lk_hit) && (&ent_valid)) |=>
         (($past(rr_ptr) == IDX_W'(ENTRIES - 1)) ? (rr_ptr == '0)
                                                 : (rr_ptr == $past(rr_ptr) + 1'b1)));

   // R5
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ev_valid && !(lk_valid && lk_hit) && (&ent_valid)) |=> $stable(rr_ptr));

endmodule

bind victim_buf victim_buf_chk #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .lk_valid      (lk_valid),
   .lk_addr       (lk_addr),
   .ev_valid      (ev_valid),
   .ev_addr       (ev_addr),
   .lk_hit        (lk_hit),
   .lk_way        (lk_way),
   .swap_valid    (swap_valid),
   .nxt_req_valid (nxt_req_valid),
   .ent_valid     (ent_valid),
   .match_vec     (match_vec),
   .rr_ptr        (rr_ptr)
);

// File: tb/victim_buf_bench.sv
module victim_buf_bench;

   localparam int N  = 4;
   localparam int AW = 26;
   localparam int LW = 64;
   localparam int IW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lk_valid = 1'b0;
   logic [AW-1:0] lk_addr = '0;
   logic          ev_valid = 1'b0;
   logic [AW-1:0] ev_addr = '0;
   logic [LW-1:0] ev_data = '0;
   logic          lk_hit, swap_valid, nxt_req_valid;
   logic [IW-1:0] lk_way;
   logic [LW-1:0] swap_data;
   logic [AW-1:0] nxt_req_addr;

   always #5 clk = ~clk;

   victim_buf #(.ENTRIES(N), .ADDR_W(AW), .LINE_W(LW)) u_victim_buf (
      .clk (clk), .rst_n (rst_n),
      .lk_valid (lk_valid), .lk_addr (lk_addr),
      .ev_valid (ev_valid), .ev_addr (ev_addr), .ev_data (ev_data),
      .lk_hit (lk_hit), .lk_way (lk_way),
      .swap_valid (swap_valid), .swap_data (swap_data),
      .nxt_req_valid (nxt_req_valid), .nxt_req_addr (nxt_req_addr)
   );

   int n_run = 0;
   int n_fail = 0;

   // reference model
   bit            m_v [N];
   int            m_a [N];
   logic [LW-1:0] m_d [N];
   int            m_ptr = 0;

   function automatic logic [LW-1:0] line_of(int a);
      return {32'(a) ^ 32'hA5C3_0000, ~32'(a)};
   endfunction

   function automatic int find(int a);
      for (int i = 0; i < N; i++) if (m_v[i] && m_a[i] == a) return i;
      return -1;
   endfunction

   task automatic chk(bit ok, string tag, string what, logic [LW-1:0] act, logic [LW-1:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic step(bit lv, int la, bit ev, int ea, string tag);
      int h;
      @(negedge clk);
      lk_valid = lv; lk_addr = AW'(la);
      ev_valid = ev; ev_addr = AW'(ea); ev_data = line_of(ea);
      #1;
      h = lv ? find(la) : -1;
      chk(lk_hit == (h >= 0), tag, "hit", LW'(lk_hit), LW'(h >= 0));
      chk(lk_way == IW'(h >= 0 ? h : 0), tag, "way", LW'(lk_way), LW'(h >= 0 ? h : 0));
      chk(swap_valid == (h >= 0), tag, "swap_valid", LW'(swap_valid), LW'(h >= 0));
      chk(swap_data == (h >= 0 ? m_d[h] : '0), tag, "swap_data", swap_data,
          h >= 0 ? m_d[h] : '0);
      chk(nxt_req_valid == (lv && h < 0), tag, "nxt_req_valid", LW'(nxt_req_valid),
          LW'(lv && h < 0));
      if (lv && h < 0)
         chk(nxt_req_addr == AW'(la), tag, "nxt_req_addr", LW'(nxt_req_addr), LW'(AW'(la)));
      // model update, applied at the coming edge
      if (h >= 0 && ev) begin
         m_a[h] = ea; m_d[h] = line_of(ea);
      end else if (h >= 0) begin
         m_v[h] = 1'b0;
      end else if (ev) begin
         int f = -1;
         for (int i = N - 1; i >= 0; i--) if (!m_v[i]) f = i;
         if (f < 0) begin
            f = m_ptr;
            m_ptr = (m_ptr + 1) % N;
         end
         m_v[f] = 1'b1; m_a[f] = ea; m_d[f] = line_of(ea);
      end
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired, R1 to R9 not all reached");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin : stim
      for (int i = 0; i < N; i++) begin m_v[i] = 0; m_a[i] = 0; m_d[i] = '0; end
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1: empty after reset
      step(1, 'h100, 0, 0, "R1");
      step(1, 0, 0, 0, "R1");
      // R4: fill empty entries in order
      step(0, 0, 1, 'h200, "R4");
      step(0, 0, 1, 'h201, "R4");
      step(0, 0, 1, 'h202, "R4");
      step(0, 0, 1, 'h203, "R4");
      // R8: lookup strobe low, address matches
      step(0, 'h201, 0, 0, "R8");
      step(1, 'h201, 1, 'h210, "R2");  // swap keeps buffer full, way 1
      step(1, 'h210, 1, 'h211, "R9");
      step(1, 'h200, 1, 'h212, "R2");
      // R3: miss goes down
      step(1, 'h3FF, 0, 0, "R3");
      // R5: full, pointer 0 then 1
      step(0, 0, 1, 'h220, "R5");
      step(1, 'h212, 0, 0, "R5");      // old entry 0 gone: miss
      step(0, 0, 1, 'h221, "R5");
      step(1, 'h221, 1, 'h222, "R6");  // swap into entry 1
      step(1, 'h222, 0, 0, "R6");      // hit entry 1, then dropped (R7)
      step(1, 'h222, 0, 0, "R7");      // now a miss
      step(0, 0, 1, 'h230, "R4");      // refills entry 1, pointer stays 2
      step(0, 0, 1, 'h231, "R5");      // replaces entry 2
      step(1, 'h240, 1, 'h232, "R5");  // miss plus eviction, entry 3
      step(0, 0, 1, 'h233, "R5");      // pointer wrapped to 0
      step(1, 'h233, 0, 0, "R5");

      // constrained random phase
      for (int k = 0; k < 400; k++) begin
         bit lv = 1'($urandom_range(0, 3) != 0);
         int la = 'h300 + int'($urandom_range(0, 11));
         bit ev = 1'($urandom_range(0, 1));
         int ea;
         do ea = 'h300 + int'($urandom_range(0, 11));
         while (find(ea) >= 0 || (lv && ea == la));
         step(lv, la, ev, ea, "R2_R5_rand");
      end

      @(negedge clk);
      lk_valid = 0; ev_valid = 0;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule